// File: doc/BRIEF.md
# IO Controller Register Bank with Serial Configuration-Memory Pins

This block is the host-visible register bank of a router IO controller. A host issues single-word reads and writes over a small request/response channel. Each request names a register offset. The bank answers with values from several sources:

- slot-presence information, returned as an active-low pattern;
- fixed identification and environment words;
- an 8-bit mask register that the host can read and write;
- two pin-control registers that let software bit-bang a serial configuration memory. One register drives the mainboard memory. The other drives the memory of one module slot, and a select field in the written word picks that slot.

The bank also holds two pending-interrupt flags, one for management events and one for external events. Outside logic sets them with single-cycle pulses. A read of the matching status offset clears the flag.

The request channel uses valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. Every transferred request, read or write, produces exactly one response one cycle later. A write's response carries zero data. While a response is held, `req_ready` stays low, so the host can hold back the bank by keeping `rsp_ready` low. The pin and presence inputs are plain levels.

Top module: `ioctl_regbank`

Register offsets: 0x0 platform ID, 0x1 environment, 0x2 flash protect, 0x3 boot-flash size, 0x4 watchdog kick, 0x5 presence, 0x6 mainboard memory pins, 0x7 slot memory pins, 0x8 management status, 0x9 external status, 0xA IO mask.

## Requirements
- R1: After `rsp_valid` rises, it stays high and `rsp_rdata` stays unchanged until a rising edge where `rsp_ready` is high. `req_ready` is low while `rsp_valid` is high. Each transferred request gives exactly one response on the next cycle.
- R2: A read of offset 0x5 returns 0xFFFF when no slot is present. For each present slot i (0..3), bits i, i+4, i+8 and i+12 read 0.
- R3: A write to offset 0x6 drives the mainboard pins from the written word: chip select from bit 0, clock from bit 1, data-in from bit 2. A read returns those three bits and the memory data-out on bit 3. All other bits read 0.
- R4: A write to offset 0x7 latches bits 1:0 as the selected slot. The selected slot's chip select, clock and data-in come from bits 4, 2 and 6 of the same word. Every slot that is not selected has chip select, clock and data-in held low. A read returns bits 6, 4, 2 and 1:0 as written, with data-out on bit 7.
- R5: Data-out reads 1 when no memory answers. For the mainboard this is when its chip select is low. For a slot it is when its chip select is low or the slot is not present.
- R6: A read of offset 0x8 returns 0 and clears the management flag. A read of offset 0x9 returns 0 and clears the external flag. A set pulse raises the flag from the next cycle. A set pulse in the same cycle as a clearing read leaves the flag set.
- R7: Offset 0xA is an 8-bit read/write register. It resets to 0, and its bits 15:8 read 0.
- R8: Offset 0x0 returns the variant code in bits 7:5: code 0, 4 or 3 for variant 0, 1 or 2. Offset 0x1 reads 0x0021, offset 0x2 reads 0x00FF and offset 0x3 reads 0x1000.
- R9: A write to offset 0x4 has no effect, and that offset reads 0. Undefined offsets read 0, and writes to them change no register or pin.
- R10: After reset, all memory pins are low, both flags are clear, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes response |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| slot_present | input | NSLOT | Module present, active high |
| mb_cs | output | 1 | Mainboard memory chip select |
| mb_sk | output | 1 | Mainboard memory clock |
| mb_di | output | 1 | Mainboard memory serial in |
| mb_do | input | 1 | Mainboard memory serial out |
| slot_cs | output | NSLOT | Per-slot memory chip select |
| slot_sk | output | NSLOT | Per-slot memory clock |
| slot_di | output | NSLOT | Per-slot memory serial in |
| slot_do | input | NSLOT | Per-slot memory serial out |
| irq_mgmt_set | input | 1 | Set pulse for management flag |
| irq_ext_set | input | 1 | Set pulse for external flag |
| irq_mgmt_pend | output | 1 | Management flag pending |
| irq_ext_pend | output | 1 | External flag pending |

## Verification
The hardest case to reach from the ports is a set pulse that lands on the same edge as the read that clears the same flag. The bench places the pulse in the same low clock phase as the status read, so both are sampled at one rising edge. It then checks that the flag is still pending afterwards.

A second hard case is a slot data-out that must be masked because the slot is empty. To reach it, the bench selects a slot, drives its serial-out line low, and then removes its presence bit before reading.

Response back-pressure is reached by holding `rsp_ready` low across several cycles.

// File: rtl/ioctl_pkg.sv
package ioctl_pkg;
  // register identifiers; the offset equals the identifier
  localparam int RID_PLAT   = 0;
  localparam int RID_ENV    = 1;
  localparam int RID_FPROT  = 2;
  localparam int RID_BFSZ   = 3;
  localparam int RID_WDOG   = 4;
  localparam int RID_PRES   = 5;
  localparam int RID_MBEE   = 6;
  localparam int RID_MODEE  = 7;
  localparam int RID_MGMT   = 8;
  localparam int RID_EXT    = 9;
  localparam int RID_IOMASK = 10;
  localparam int NREG       = 11;

  // pending-flag indices
  localparam int FLG_MGMT = 0;
  localparam int FLG_EXT  = 1;
  localparam int NFLAG    = 2;

  function automatic logic [2:0] variant_code(input int v);
    case (v)
      1:       return 3'd4;
      2:       return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ioctl_decode.sv
module ioctl_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar k = 0; k < NREG; k++) begin : g_hit
    assign hit[k] = (addr == ADDR_W'(k));
  end
endmodule

// File: rtl/ioctl_irq_flags.sv
module ioctl_irq_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      for (int g = 0; g < NFLAG; g++) begin
        if (set[g])      pend[g] <= 1'b1;
        else if (clr[g]) pend[g] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_chk
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> pend[g]);                       // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] && !set[g] |=> !pend[g]);           // R6
  end
endmodule

// File: rtl/ioctl_eeprom_pins.sv
module ioctl_eeprom_pins #(
  parameter int NSLOT  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mb_we,
  input  logic              mod_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSLOT-1:0]  slot_present,
  input  logic              mb_do,
  input  logic [NSLOT-1:0]  slot_do,
  output logic              mb_cs,
  output logic              mb_sk,
  output logic              mb_di,
  output logic [NSLOT-1:0]  slot_cs,
  output logic [NSLOT-1:0]  slot_sk,
  output logic [NSLOT-1:0]  slot_di,
  output logic [DATA_W-1:0] mb_rd,
  output logic [DATA_W-1:0] mod_rd
);
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  // pin positions in the two control words
  localparam int MB_CS_B  = 0;
  localparam int MB_SK_B  = 1;
  localparam int MB_DI_B  = 2;
  localparam int MB_DO_B  = 3;
  localparam int MD_SK_B  = 2;
  localparam int MD_CS_B  = 4;
  localparam int MD_DI_B  = 6;
  localparam int MD_DO_B  = 7;

  logic             mb_cs_q, mb_sk_q, mb_di_q;
  logic             md_cs_q, md_sk_q, md_di_q;
  logic [SEL_W-1:0] md_sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_cs_q  <= 1'b0;
      mb_sk_q  <= 1'b0;
      mb_di_q  <= 1'b0;
      md_cs_q  <= 1'b0;
      md_sk_q  <= 1'b0;
      md_di_q  <= 1'b0;
      md_sel_q <= '0;
    end else begin
      if (mb_we) begin
        mb_cs_q <= wdata[MB_CS_B];
        mb_sk_q <= wdata[MB_SK_B];
        mb_di_q <= wdata[MB_DI_B];
      end
      if (mod_we) begin
        md_cs_q  <= wdata[MD_CS_B];
        md_sk_q  <= wdata[MD_SK_B];
        md_di_q  <= wdata[MD_DI_B];
        md_sel_q <= wdata[SEL_W-1:0];
      end
    end
  end

  assign mb_cs = mb_cs_q;
  assign mb_sk = mb_sk_q;
  assign mb_di = mb_di_q;

  // only the selected slot sees the pins; the rest idle low
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic chosen;
    assign chosen     = (md_sel_q == SEL_W'(s));
    assign slot_cs[s] = chosen & md_cs_q;
    assign slot_sk[s] = chosen & md_sk_q;
    assign slot_di[s] = chosen & md_di_q;
  end

  // a silent memory leaves data-out pulled high
  logic md_dout;
  assign md_dout = ~|(slot_cs & slot_present & ~slot_do);

  always_comb begin
    mb_rd           = '0;
    mb_rd[MB_CS_B]  = mb_cs_q;
    mb_rd[MB_SK_B]  = mb_sk_q;
    mb_rd[MB_DI_B]  = mb_di_q;
    mb_rd[MB_DO_B]  = mb_cs_q ? mb_do : 1'b1;
    mod_rd          = '0;
    mod_rd[1:0]     = 2'(md_sel_q);
    mod_rd[MD_SK_B] = md_sk_q;
    mod_rd[MD_CS_B] = md_cs_q;
    mod_rd[MD_DI_B] = md_di_q;
    mod_rd[MD_DO_B] = md_dout;
  end

  AST_MB_CS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mb_we |=> mb_cs == $past(wdata[MB_CS_B]));                          // R3
  AST_SLOT_CS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mod_we |=> (|slot_cs) == $past(wdata[MD_CS_B]));                    // R4
  AST_SLOT_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_we |=> $stable(slot_cs) && $stable(slot_sk) && $stable(slot_di)); // R4
endmodule

// File: rtl/ioctl_regbank.sv
module ioctl_regbank
  import ioctl_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NSLOT-1:0]  slot_present,
  output logic              mb_cs,
  output logic              mb_sk,
  output logic              mb_di,
  input  logic              mb_do,
  output logic [NSLOT-1:0]  slot_cs,
  output logic [NSLOT-1:0]  slot_sk,
  output logic [NSLOT-1:0]  slot_di,
  input  logic [NSLOT-1:0]  slot_do,
  input  logic              irq_mgmt_set,
  input  logic              irq_ext_set,
  output logic              irq_mgmt_pend,
  output logic              irq_ext_pend
);
  localparam int          PRES_W  = 4 * NSLOT;
  localparam int          MASK_W  = 8;
  localparam logic [2:0]  PCODE   = variant_code(VARIANT);

  logic            accept, rd_en, wr_en;
  logic [NREG-1:0] hit;

  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;
  assign rd_en     = accept & ~req_write;
  assign wr_en     = accept & req_write;

  ioctl_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  // IO mask
  logic [MASK_W-1:0] iomask_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      iomask_q <= '0;
    else if (wr_en && hit[RID_IOMASK]) iomask_q <= req_wdata[MASK_W-1:0];
  end

  // serial memory pins
  logic [DATA_W-1:0] mb_rd, mod_rd;
  ioctl_eeprom_pins #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .mb_we        (wr_en & hit[RID_MBEE]),
    .mod_we       (wr_en & hit[RID_MODEE]),
    .wdata        (req_wdata),
    .slot_present (slot_present),
    .mb_do        (mb_do),
    .slot_do      (slot_do),
    .mb_cs        (mb_cs),
    .mb_sk        (mb_sk),
    .mb_di        (mb_di),
    .slot_cs      (slot_cs),
    .slot_sk      (slot_sk),
    .slot_di      (slot_di),
    .mb_rd        (mb_rd),
    .mod_rd       (mod_rd)
  );

  // pending flags, cleared by status reads
  logic [NFLAG-1:0] flg_set, flg_clr, flg_pend;
  assign flg_set[FLG_MGMT] = irq_mgmt_set;
  assign flg_set[FLG_EXT]  = irq_ext_set;
  assign flg_clr[FLG_MGMT] = rd_en & hit[RID_MGMT];
  assign flg_clr[FLG_EXT]  = rd_en & hit[RID_EXT];

  ioctl_irq_flags #(.NFLAG(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flg_set),
    .clr   (flg_clr),
    .pend  (flg_pend)
  );
  assign irq_mgmt_pend = flg_pend[FLG_MGMT];
  assign irq_ext_pend  = flg_pend[FLG_EXT];

  // presence: each slot bit repeated in all four nibble lanes, active low
  logic [PRES_W-1:0] pres_word;
  for (genvar k = 0; k < 4; k++) begin : g_lane
    for (genvar i = 0; i < NSLOT; i++) begin : g_bit
      assign pres_word[k*NSLOT+i] = ~slot_present[i];
    end
  end

  // read mux
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit[RID_PLAT])   rd_val = DATA_W'({PCODE, 5'b0});
    if (hit[RID_ENV])    rd_val = DATA_W'(16'h0021);
    if (hit[RID_FPROT])  rd_val = DATA_W'(16'h00FF);
    if (hit[RID_BFSZ])   rd_val = DATA_W'(16'h1000);
    if (hit[RID_PRES])   rd_val = DATA_W'(pres_word);
    if (hit[RID_MBEE])   rd_val = mb_rd;
    if (hit[RID_MODEE])  rd_val = mod_rd;
    if (hit[RID_IOMASK]) rd_val = DATA_W'(iomask_q);
  end

  // response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));   // R1
  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);                          // R1
  AST_IOMASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit[RID_IOMASK] |=> iomask_q == $past(req_wdata[MASK_W-1:0])); // R7
endmodule

// File: tb/ioctl_regbank_test.sv
module ioctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata;
  logic [3:0]  slot_present = '0, slot_do = '0;
  logic        mb_do = 1'b0, mb_cs, mb_sk, mb_di;
  logic [3:0]  slot_cs, slot_sk, slot_di;
  logic        irq_mgmt_set = 1'b0, irq_ext_set = 1'b0;
  logic        irq_mgmt_pend, irq_ext_pend;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  ioctl_regbank #(.NSLOT(4), .VARIANT(1)) uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .slot_present,
    .mb_cs, .mb_sk, .mb_di, .mb_do, .slot_cs, .slot_sk, .slot_di, .slot_do,
    .irq_mgmt_set, .irq_ext_set, .irq_mgmt_pend, .irq_ext_pend
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [15:0] d,
                     output logic [15:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 pins", {mb_cs, mb_sk, mb_di, slot_cs, slot_sk, slot_di}, 0);
    chk("R10 flags", {irq_mgmt_pend, irq_ext_pend}, 0);
    chk("R10 handshake", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_consts;
    logic [15:0] q;
    bus(0, 8'h0, 0, q); chk("R8 platform", q, 16'h0080);
    bus(0, 8'h1, 0, q); chk("R8 env", q, 16'h0021);
    bus(0, 8'h2, 0, q); chk("R8 flash protect", q, 16'h00FF);
    bus(0, 8'h3, 0, q); chk("R8 boot size", q, 16'h1000);
  endtask

  task automatic t_presence;
    logic [15:0] q;
    slot_present = 4'b0000; bus(0, 8'h5, 0, q); chk("R2 none", q, 16'hFFFF);
    slot_present = 4'b0101; bus(0, 8'h5, 0, q); chk("R2 slots0,2", q, 16'hAAAA);
    slot_present = 4'b0010; bus(0, 8'h5, 0, q); chk("R2 slot1", q, 16'hDDDD);
    slot_present = 4'b1111; bus(0, 8'h5, 0, q); chk("R2 all", q, 16'h0000);
  endtask

  task automatic t_mb;
    logic [15:0] q;
    bus(1, 8'h6, 16'h0007, q);
    chk("R3 pins set", {mb_cs, mb_sk, mb_di}, 3'b111);
    chk("R1 write rsp zero", q, 0);
    mb_do = 1'b0; bus(0, 8'h6, 0, q); chk("R3 read do=0", q, 16'h0007);
    mb_do = 1'b1; bus(0, 8'h6, 0, q); chk("R3 read do=1", q, 16'h000F);
    bus(1, 8'h6, 16'h0006, q); mb_do = 1'b0;
    bus(0, 8'h6, 0, q); chk("R5 mb cs low reads 1", q, 16'h000E);
    bus(1, 8'h6, 16'hFFF8, q);
    chk("R3 upper bits ignored", {mb_cs, mb_sk, mb_di}, 3'b000);
  endtask

  task automatic t_mod;
    logic [15:0] q;
    slot_present = 4'b1111; slot_do = 4'b1011;
    bus(1, 8'h7, 16'h0056, q);
    chk("R4 cs slot2", slot_cs, 4'b0100);
    chk("R4 sk slot2", slot_sk, 4'b0100);
    chk("R4 di slot2", slot_di, 4'b0100);
    bus(0, 8'h7, 0, q); chk("R4 read do=0", q, 16'h0056);
    slot_do = 4'b0100; bus(0, 8'h7, 0, q); chk("R4 read do=1", q, 16'h00D6);
    slot_do = 4'b1011; slot_present = 4'b1011;
    bus(0, 8'h7, 0, q); chk("R5 empty slot reads 1", q, 16'h00D6);
    slot_present = 4'b1111;
    bus(1, 8'h7, 16'h0046, q);
    chk("R4 cs low", slot_cs, 4'b0000);
    bus(0, 8'h7, 0, q); chk("R5 slot cs low reads 1", q, 16'h00C6);
    bus(1, 8'h7, 16'h0053, q);
    chk("R4 slot3 pins", {slot_cs, slot_di}, 8'b1000_1000);
    chk("R4 slot3 sk low", slot_sk, 4'b0000);
  endtask

  task automatic t_irq;
    logic [15:0] q;
    @(negedge clk); irq_mgmt_set = 1'b1; irq_ext_set = 1'b1;
    @(negedge clk); irq_mgmt_set = 1'b0; irq_ext_set = 1'b0;
    chk("R6 set both", {irq_mgmt_pend, irq_ext_pend}, 2'b11);
    bus(0, 8'h8, 0, q);
    chk("R6 mgmt read zero", q, 0);
    chk("R6 mgmt cleared ext kept", {irq_mgmt_pend, irq_ext_pend}, 2'b01);
    bus(0, 8'h9, 0, q);
    chk("R6 ext read zero", q, 0);
    chk("R6 ext cleared", irq_ext_pend, 0);
    @(negedge clk);
    irq_mgmt_set = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h8;
    @(negedge clk);
    irq_mgmt_set = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R6 set wins over clear", irq_mgmt_pend, 1);
    bus(0, 8'h8, 0, q);
    chk("R6 mgmt cleared again", irq_mgmt_pend, 0);
  endtask

  task automatic t_iomask;
    logic [15:0] q;
    bus(0, 8'hA, 0, q); chk("R7 reset value", q, 0);
    bus(1, 8'hA, 16'hA5C3, q);
    bus(0, 8'hA, 0, q); chk("R7 readback 8 bits", q, 16'h00C3);
  endtask

  task automatic t_ignored;
    logic [15:0] q;
    logic [3:0] cs0;
    cs0 = slot_cs;
    bus(1, 8'h4, 16'h7D00, q);
    bus(0, 8'h4, 0, q); chk("R9 watchdog reads 0", q, 0);
    bus(1, 8'h3F, 16'hFFFF, q);
    bus(0, 8'h3F, 0, q); chk("R9 undefined reads 0", q, 0);
    bus(0, 8'hA, 0, q); chk("R9 iomask untouched", q, 16'h00C3);
    chk("R9 pins untouched", {slot_cs, mb_cs}, {cs0, 1'b0});
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h1;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 8'h2;
    chk("R1 rsp valid", {rsp_valid, req_ready}, 2'b10);
    chk("R1 rsp data", rsp_rdata, 16'h0021);
    repeat (3) @(negedge clk);
    chk("R1 held", {rsp_valid, req_ready}, 2'b10);
    chk("R1 data stable", rsp_rdata, 16'h0021);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R1 released", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_consts();
    t_presence();
    t_mb();
    t_mod();
    t_irq();
    t_iomask();
    t_ignored();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule